// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a processor core and turns a set of event-type interrupt requests into a single program address. Each request line, when pulsed, sets a pending flag that stays set until the core services it. At an instruction boundary the controller checks three things: the global enable is set, at least one flag is pending, and that flag's own enable is set. When all three hold, it picks the pending, enabled source with the lowest number. It then presents the vector address of that source and drops the global enable in the same clock edge. The core pushes its return address (outside this block) and acknowledges. The acknowledge clears the flag of the serviced source. A return-from-interrupt strobe, or a software set, turns the global enable back on. A handler that sets the enable early can therefore be interrupted again.

Vector slot 0 belongs to reset, and source k occupies slot k+1, so a lower source number is both a lower address and a higher priority. Each slot is two program words wide. A dynamic control input moves the interrupt vectors from address zero to a boot-section base. A separate static input chooses where the reset vector lives.

The controller has two states. ST_IDLE waits for a qualified boundary. ST_VECTOR holds the chosen vector until the core acknowledges. The transition TAKE (ST_IDLE to ST_VECTOR) fires on a boundary strobe while the global enable is set and an enabled flag is pending. The transition DONE (ST_VECTOR to ST_IDLE) fires on the acknowledge. Without a qualified boundary the controller stays in ST_IDLE, and without an acknowledge it stays in ST_VECTOR.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the global enable is 0, all pending flags are 0, `take_o` is 0 and the controller is in ST_IDLE.
- R2: A 1 on bit k of `req_i` at a clock edge sets pending flag k (`flags_o[k]`). The flag stays set, whether or not interrupts are masked, until its own acknowledge.
- R3: An interrupt is taken only at an edge where all of the following hold: `boundary_i` is 1, the global enable is 1, the controller is in ST_IDLE, and `flags_o & src_en_i` is nonzero. Otherwise `take_o` stays 0.
- R4: Among pending flags whose `src_en_i` bit is 1, the lowest bit index wins.
- R5: The vector address is base + 2*(k+1) for source k. Slot 0 is the reset slot.
- R6: The base is 0 when `vec_boot_i` is 0 and BOOT_BASE (default 0x3800) when it is 1. It is sampled at the TAKE edge and held while `take_o` is 1.
- R7: `reset_vec_o` is 0 when `rst_boot_i` is 0 and BOOT_BASE when it is 1.
- R8: The TAKE edge clears the global enable. `take_o` is 1 from that edge until the acknowledge edge.
- R9: `ack_i` while `take_o` is 1 clears only the serviced flag. A request on the same bit in the same cycle leaves it set.
- R10: `reti_i` or `gie_set_i` sets the global enable. `gie_clr_i` clears it and wins over a set. A TAKE edge clears it and wins over all of them.
- R11: While `take_o` is 1, further boundary strobes start no new interrupt, and `vec_addr_o` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Event requests, one per source |
| src_en_i | input | NUM_SRC | Per-source enable bits |
| gie_set_i | input | 1 | Software set of the global enable |
| gie_clr_i | input | 1 | Software clear of the global enable |
| reti_i | input | 1 | Return-from-interrupt strobe |
| boundary_i | input | 1 | Instruction boundary strobe |
| ack_i | input | 1 | Core acknowledge of the offered vector |
| vec_boot_i | input | 1 | Interrupt vectors placed at the boot base |
| rst_boot_i | input | 1 | Static: reset vector placed at the boot base |
| take_o | output | 1 | Interrupt offered, waiting for acknowledge |
| vec_addr_o | output | PC_W | Vector address of the offered interrupt |
| reset_vec_o | output | PC_W | Reset vector address |
| gie_o | output | 1 | Global enable state |
| flags_o | output | NUM_SRC | Pending flags |

## Verification
The priority path is driven with the following request and enable patterns, each chosen to separate one kind of fault:
- a single low source and a single high source, which tell a wrong slot offset apart from a reversed encoder;
- two or more pending sources, which show that the lowest index wins;
- a pending source whose enable bit is 0 next to an enabled higher-numbered one, which shows the enable mask is applied before the encoder;
- all enables off, and no request at all, both of which must produce no TAKE;
- the same patterns with the boot base selected, which catch a base that is missing or added twice.

Directed cases cover the remaining timing:
- a flag raised while masked, then serviced once the enable returns;
- a pending flag with no boundary strobe;
- a boundary strobe and a software set in the same cycle;
- an acknowledge and a new request on the same bit in the same cycle;
- boundaries and base changes while a vector is being offered.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_VECTOR = 1'b1
    } irq_state_e;

    // Slot 0 is reserved for reset, so source k sits in slot k+1, two words per slot.
    function automatic logic [31:0] slot_offset(input logic [31:0] src);
        return (src + 32'd1) << 1;
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flag_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set_i[g]) begin
                flag_q <= 1'b1;          // a new event wins over a clear
            end else if (clr_i[g]) begin
                flag_q <= 1'b0;
            end
        end
        assign flag_o[g] = flag_q;
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_gie_reg.sv
module irq_gie_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic clr_i,
    input  logic set_i,
    output logic gie_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_o <= 1'b0;
        end else if (take_i || clr_i) begin
            gie_o <= 1'b0;
        end else if (set_i) begin
            gie_o <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int          NUM_SRC   = 8,
    parameter int          PC_W      = 16,
    parameter logic [31:0] BOOT_BASE = 32'h0000_3800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               gie_set_i,
    input  logic               gie_clr_i,
    input  logic               reti_i,
    input  logic               boundary_i,
    input  logic               ack_i,
    input  logic               vec_boot_i,
    input  logic               rst_boot_i,
    output logic               take_o,
    output logic [PC_W-1:0]    vec_addr_o,
    output logic [PC_W-1:0]    reset_vec_o,
    output logic               gie_o,
    output logic [NUM_SRC-1:0] flags_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [PC_W-1:0] BOOT_PC = PC_W'(BOOT_BASE);

    irq_state_e           state_q, state_d;
    logic [IDX_W-1:0]     win_idx, win_q;
    logic                 win_hit;
    logic                 take_start;
    logic                 done;
    logic [NUM_SRC-1:0]   clr_mask;
    logic [PC_W-1:0]      vec_q, vec_d;

    irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_i),
        .clr_i  (clr_mask),
        .flag_o (flags_o)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend_i (flags_o & src_en_i),
        .hit_o  (win_hit),
        .idx_o  (win_idx)
    );

    irq_gie_reg u_gie (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take_start),
        .clr_i  (gie_clr_i),
        .set_i  (gie_set_i || reti_i),
        .gie_o  (gie_o)
    );

    assign take_start = (state_q == ST_IDLE) && boundary_i && gie_o && win_hit;
    assign done       = (state_q == ST_VECTOR) && ack_i;

    // next-state logic: TAKE and DONE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_start) state_d = ST_VECTOR;
            ST_VECTOR: if (done)       state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // vector computed from the winner and the base selected at TAKE
    always_comb begin
        vec_d = (vec_boot_i ? BOOT_PC : '0) + PC_W'(slot_offset(32'(win_idx)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            vec_q <= '0;
        end else if (take_start) begin
            win_q <= win_idx;
            vec_q <= vec_d;
        end
    end

    // output process
    always_comb begin
        clr_mask    = '0;
        take_o      = 1'b0;
        vec_addr_o  = vec_q;
        reset_vec_o = rst_boot_i ? BOOT_PC : '0;
        unique case (state_q)
            ST_IDLE: begin
                take_o = 1'b0;
            end
            ST_VECTOR: begin
                take_o = 1'b1;
                if (ack_i) clr_mask[win_q] = 1'b1;
            end
            default: begin
                take_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int PC_W    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               boundary_i,
    input logic               ack_i,
    input logic               reti_i,
    input logic               gie_clr_i,
    input logic               take_o,
    input logic [PC_W-1:0]    vec_addr_o,
    input logic               gie_o,
    input logic [NUM_SRC-1:0] flags_o
);
    p_take_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> ($past(gie_o) && $past(boundary_i)));

    p_gie_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> !gie_o);

    p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(take_o)) |-> $stable(vec_addr_o));

    p_vec_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vec_addr_o[0] == 1'b0));

    p_ack_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ack_i) |=> !take_o);

    p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_o && ack_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    p_one_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ack_i) |=> ($countones($past(flags_o) & ~flags_o) <= 1));

    p_reti_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && reti_i && !gie_clr_i) |=> gie_o);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .ack_i      (ack_i),
    .reti_i     (reti_i),
    .gie_clr_i  (gie_clr_i),
    .take_o     (take_o),
    .vec_addr_o (vec_addr_o),
    .gie_o      (gie_o),
    .flags_o    (flags_o)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
    localparam int N = 8;
    localparam int W = 16;
    localparam logic [15:0] BOOT = 16'h3800;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] src_en_i = '0;
    logic         gie_set_i = 1'b0, gie_clr_i = 1'b0, reti_i = 1'b0;
    logic         boundary_i = 1'b0, ack_i = 1'b0;
    logic         vec_boot_i = 1'b0, rst_boot_i = 1'b0;
    logic         take_o, gie_o;
    logic [W-1:0] vec_addr_o, reset_vec_o;
    logic [N-1:0] flags_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irq_vector_ctrl #(.NUM_SRC(N), .PC_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .src_en_i(src_en_i),
        .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .reti_i(reti_i),
        .boundary_i(boundary_i), .ack_i(ack_i), .vec_boot_i(vec_boot_i),
        .rst_boot_i(rst_boot_i), .take_o(take_o), .vec_addr_o(vec_addr_o),
        .reset_vec_o(reset_vec_o), .gie_o(gie_o), .flags_o(flags_o)
    );

    // req, en, boot, expect take, expect vector
    localparam logic [33:0] TBL [8] = '{
        {8'h01, 8'hFF, 1'b0, 1'b1, 16'h0002},
        {8'h80, 8'hFF, 1'b0, 1'b1, 16'h0010},
        {8'h90, 8'hFF, 1'b0, 1'b1, 16'h000A},
        {8'h0C, 8'h08, 1'b0, 1'b1, 16'h0008},
        {8'h0F, 8'h00, 1'b0, 1'b0, 16'h0000},
        {8'h06, 8'hFF, 1'b1, 1'b1, 16'h3804},
        {8'hFF, 8'hF0, 1'b1, 1'b1, 16'h380A},
        {8'h00, 8'hFF, 1'b0, 1'b0, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_req(input logic [N-1:0] m);
        req_i = m; tick(); req_i = '0;
    endtask

    task automatic pulse_set();
        gie_set_i = 1'b1; tick(); gie_set_i = 1'b0;
    endtask

    task automatic pulse_bnd();
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1; tick(); ack_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 gie", 32'(gie_o), 0);
        chk("R1 flags", 32'(flags_o), 0);
        chk("R1 take", 32'(take_o), 0);
        // R7 reset vector placement
        rst_boot_i = 1'b0; #1;
        chk("R7 reset_vec low", 32'(reset_vec_o), 0);
        rst_boot_i = 1'b1; #1;
        chk("R7 reset_vec boot", 32'(reset_vec_o), 32'(BOOT));
        rst_boot_i = 1'b0;

        // table walk: R4 R5 R6 R3 R8 R9
        foreach (TBL[i]) begin
            logic [N-1:0] rq, en, win;
            logic bt, et;
            logic [15:0] ev;
            {rq, en, bt, et, ev} = TBL[i];
            do_reset();
            vec_boot_i = bt;
            src_en_i = en;
            pulse_set();
            if (rq != 0) pulse_req(rq);
            chk("R2 flags set", 32'(flags_o), 32'(rq));
            pulse_bnd();
            chk("R3/R4 take", 32'(take_o), 32'(et));
            if (et) begin
                chk("R5/R6 vector", 32'(vec_addr_o), 32'(ev));
                chk("R8 gie dropped", 32'(gie_o), 0);
                win = '0;
                for (int b = N - 1; b >= 0; b--) if (rq[b] && en[b]) win = N'(1) << b;
                pulse_ack();
                chk("R9 take end", 32'(take_o), 0);
                chk("R9 only winner cleared", 32'(flags_o), 32'(rq & ~win));
            end else begin
                chk("R3 gie kept", 32'(gie_o), 1);
            end
        end

        // R2/R3 masked flag stays pending, serviced later
        do_reset();
        src_en_i = '1;
        vec_boot_i = 1'b0;
        pulse_req(8'h04);
        pulse_bnd();
        chk("R3 masked no take", 32'(take_o), 0);
        chk("R2 flag held masked", 32'(flags_o), 32'h04);
        pulse_set();
        repeat (3) tick();
        chk("R3 no boundary no take", 32'(take_o), 0);
        pulse_bnd();
        chk("R2 serviced later", 32'(take_o), 1);
        chk("R5 vector src2", 32'(vec_addr_o), 32'h6);

        // R11 boundaries and base changes during the offer
        vec_boot_i = 1'b1;
        pulse_req(8'h01);
        pulse_bnd();
        chk("R11 still offered", 32'(take_o), 1);
        chk("R6/R11 vector held", 32'(vec_addr_o), 32'h6);

        // R9 ack and same-bit request together
        ack_i = 1'b1; req_i = 8'h04; tick(); ack_i = 1'b0; req_i = '0;
        chk("R9 take end", 32'(take_o), 0);
        chk("R9 re-request kept", 32'(flags_o), 32'h05);

        // R10 reti sets; clear wins over set
        reti_i = 1'b1; tick(); reti_i = 1'b0;
        chk("R10 reti sets gie", 32'(gie_o), 1);
        gie_set_i = 1'b1; gie_clr_i = 1'b1; tick(); gie_set_i = 1'b0; gie_clr_i = 1'b0;
        chk("R10 clear wins", 32'(gie_o), 0);
        // R10 take wins over a set in the same cycle
        pulse_set();
        boundary_i = 1'b1; gie_set_i = 1'b1; tick(); boundary_i = 1'b0; gie_set_i = 1'b0;
        chk("R10 take wins", 32'(gie_o), 0);
        chk("R4/R6 boot vector src0", 32'(vec_addr_o), 32'h3802);
        pulse_ack();
        chk("R9 src0 cleared", 32'(flags_o), 32'h04);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule